// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns the parts of an outgoing Ethernet frame into one byte stream. A start strobe captures a destination address, the local station address and a 16-bit type value. The block then emits the 14-byte header, passes the payload through from an upstream byte stream, and appends zero bytes when the frame would otherwise be shorter than the minimum. Output uses a valid/ready handshake. When the last byte has been accepted, the block reports the frame length. The reported length excludes the CRC, which a later stage adds.

Frames with payloads longer than the standard maximum are cut at that maximum. The rest of the payload is drained and discarded, and an error flag marks the frame. The block also protects a downstream transmit FIFO that has a known overflow weakness. After each frame it compares the frame's byte count with a safety limit: room for a maximum-size frame plus slack, subtracted from the FIFO size. If the frame is larger than that limit, a sticky "queue full" flag rises, and software or a sequencer clears it.

Top module: `txf_assembler`

## Requirements
- R1: After a start strobe the first 14 output bytes are the header. Bytes 0..5 are `dst_addr_i[47:40]` down to `dst_addr_i[7:0]`. Bytes 6..11 are `src_addr_i` in the same most-significant-first order. Byte 12 is `type_i[15:8]` and byte 13 is `type_i[7:0]`.
- R2: Payload bytes follow the header from byte offset 14, unchanged and in arrival order.
- R3: When header plus payload is below 60 bytes, zero bytes are appended until the frame holds exactly 60 bytes. Otherwise no byte is appended.
- R4: `done_o` is high for exactly one cycle, in the cycle after the final byte of the frame is accepted. `frame_len_o` then equals the number of bytes emitted and holds that value until the next frame completes.
- R5: While `tx_valid_o` is high and `tx_ready_i` is low, the next cycle keeps `tx_valid_o` high and `tx_data_o` unchanged.
- R6: `pl_ready_o` stays low while header bytes or pad bytes are being emitted, and while no frame is in progress.
- R7: `q_full_o` rises at frame completion when the frame length exceeds 518 (2048 − 1514 − 16). It stays high through later frames of any size.
- R8: `q_clr_i` clears `q_full_o` on the next clock edge unless a frame longer than 518 completes in that same cycle. Reset also clears it.
- R9: If a payload goes past 1500 bytes, only its first 1500 bytes are emitted. The remaining bytes are accepted and dropped up to and including the one with `pl_last_i`. The frame reports length 1514, and `trunc_err_o` stays high from then until the next start. A payload of exactly 1500 bytes sets no error.
- R10: A start strobe that arrives while a frame is in progress has no effect on the frame being emitted.
- R11: After reset, `tx_valid_o`, `pl_ready_o`, `done_o`, `q_full_o` and `trunc_err_o` are low and `frame_len_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame; captures address and type inputs when idle |
| dst_addr_i | input | 48 | Destination address, first byte in bits 47:40 |
| src_addr_i | input | 48 | Station (source) address, first byte in bits 47:40 |
| type_i | input | 16 | Type field, high byte sent first |
| pl_data_i | input | 8 | Payload byte |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_last_i | input | 1 | Marks the final payload byte |
| pl_ready_o | output | 1 | Payload byte accepted when high with valid |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_ready_i | input | 1 | Downstream accepts frame byte |
| done_o | output | 1 | One-cycle frame completion strobe |
| frame_len_o | output | 11 | Length of the last completed frame, CRC excluded |
| trunc_err_o | output | 1 | Last frame's payload was truncated |
| q_clr_i | input | 1 | Synchronous clear of the queue-full flag |
| q_full_o | output | 1 | Sticky queue-full flag |

## Verification
The output-hold property assumes an upstream that behaves like a proper stream source: once it raises `pl_valid_i`, it keeps the same byte and last flag until the byte is taken. The stimulus source meets this by indexing a fixed payload array with a counter that advances only on an accepted handshake. The tests pause downstream readiness on a pseudo-random pattern, drive a start strobe into a frame that is already running, and cover payload lengths on both sides of the pad limit, the full-flag limit and the truncation limit.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_PAY  = 3'd2,
        ST_PAD  = 3'd3,
        ST_DROP = 3'd4
    } txf_state_e;

    localparam int unsigned TXF_OCTET_W = 8;

endpackage

// File: rtl/txf_hdr_pick.sv
module txf_hdr_pick #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned TYPE_W = 16,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [TYPE_W-1:0] type_i,
    output logic [7:0]        byte_o
);
    localparam int unsigned HDR_BITS  = 2 * ADDR_W + TYPE_W;
    localparam int unsigned HDR_BYTES = HDR_BITS / 8;

    logic [HDR_BITS-1:0] hdr_vec;
    logic [7:0]          hdr_bytes [HDR_BYTES];

    assign hdr_vec = {dst_i, src_i, type_i};

    // Byte g of the header is taken most-significant first.
    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_split
        assign hdr_bytes[g] = hdr_vec[HDR_BITS-1-8*g -: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < HDR_BYTES; k++) begin
            if (int'(idx_i) == k) byte_o = hdr_bytes[k];
        end
    end
endmodule

// File: rtl/txf_qguard.sv
module txf_qguard #(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned LIMIT   = 518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             clr_i,
    output logic             full_o
);
    logic full_d, full_q;

    always_comb begin
        full_d = full_q;
        if (set_i && (len_i > LEN_W'(LIMIT))) full_d = 1'b1;
        else if (clr_i)                       full_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b0;
        else        full_q <= full_d;
    end

    assign full_o = full_q;

    // R8: the flag only drops after a clear request
    assert_full_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(clr_i));
endmodule

// File: rtl/txf_assembler.sv
module txf_assembler
    import txf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 48,
    parameter int unsigned TYPE_W      = 16,
    parameter int unsigned LEN_W       = 11,
    parameter int unsigned MIN_FRAME   = 60,
    parameter int unsigned MAX_PAYLOAD = 1500,
    parameter int unsigned FIFO_BYTES  = 2048,
    parameter int unsigned FIFO_SLACK  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [7:0]        pl_data_i,
    input  logic              pl_valid_i,
    input  logic              pl_last_i,
    output logic              pl_ready_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              done_o,
    output logic [LEN_W-1:0]  frame_len_o,
    output logic              trunc_err_o,
    input  logic              q_clr_i,
    output logic              q_full_o
);
    localparam int unsigned HDR_LEN   = (2 * ADDR_W + TYPE_W) / 8;
    localparam int unsigned MAX_FRAME = HDR_LEN + MAX_PAYLOAD;
    localparam int unsigned FULL_LIM  = FIFO_BYTES - MAX_FRAME - FIFO_SLACK;
    localparam int unsigned IDX_W     = $clog2(HDR_LEN);

    typedef struct packed {
        txf_state_e        state;
        logic [LEN_W-1:0]  off;
        logic [LEN_W-1:0]  pcnt;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic [TYPE_W-1:0] typ;
        logic              done;
        logic [LEN_W-1:0]  len;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic [7:0] hdr_byte;

    txf_hdr_pick #(
        .ADDR_W(ADDR_W),
        .TYPE_W(TYPE_W),
        .IDX_W (IDX_W)
    ) u_hdr (
        .idx_i (r_q.off[IDX_W-1:0]),
        .dst_i (r_q.dst),
        .src_i (r_q.src),
        .type_i(r_q.typ),
        .byte_o(hdr_byte)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        tx_valid_o = 1'b0;
        tx_data_o  = 8'h00;
        pl_ready_o = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.dst   = dst_addr_i;
                    r_d.src   = src_addr_i;
                    r_d.typ   = type_i;
                    r_d.off   = '0;
                    r_d.pcnt  = '0;
                    r_d.err   = 1'b0;
                    r_d.state = ST_HDR;
                end
            end
            ST_HDR: begin
                tx_valid_o = 1'b1;
                tx_data_o  = hdr_byte;
                if (tx_ready_i) begin
                    r_d.off = r_q.off + 1'b1;
                    if (r_q.off == LEN_W'(HDR_LEN - 1)) r_d.state = ST_PAY;
                end
            end
            ST_PAY: begin
                tx_valid_o = pl_valid_i;
                tx_data_o  = pl_data_i;
                pl_ready_o = tx_ready_i;
                if (pl_valid_i && tx_ready_i) begin
                    r_d.off  = r_q.off + 1'b1;
                    r_d.pcnt = r_q.pcnt + 1'b1;
                    if (pl_last_i) begin
                        if ((r_q.off + 1'b1) < LEN_W'(MIN_FRAME)) begin
                            r_d.state = ST_PAD;
                        end else begin
                            r_d.done  = 1'b1;
                            r_d.len   = r_q.off + 1'b1;
                            r_d.state = ST_IDLE;
                        end
                    end else if ((r_q.pcnt + 1'b1) == LEN_W'(MAX_PAYLOAD)) begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_DROP;
                    end
                end
            end
            ST_PAD: begin
                tx_valid_o = 1'b1;
                tx_data_o  = 8'h00;
                if (tx_ready_i) begin
                    r_d.off = r_q.off + 1'b1;
                    if ((r_q.off + 1'b1) == LEN_W'(MIN_FRAME)) begin
                        r_d.done  = 1'b1;
                        r_d.len   = r_q.off + 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_DROP: begin
                pl_ready_o = 1'b1;
                if (pl_valid_i && pl_last_i) begin
                    r_d.done  = 1'b1;
                    r_d.len   = r_q.off;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    txf_qguard #(
        .LEN_W(LEN_W),
        .LIMIT(FULL_LIM)
    ) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (r_d.done),
        .len_i (r_d.len),
        .clr_i (q_clr_i),
        .full_o(q_full_o)
    );

    assign done_o      = r_q.done;
    assign frame_len_o = r_q.len;
    assign trunc_err_o = r_q.err;

    // R5: a stalled byte stays on the output (relies on a well-behaved upstream)
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    // R4: completion strobe lasts one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: no completed frame is below the minimum
    assert_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> frame_len_o >= LEN_W'(MIN_FRAME));

    // R9: a truncated frame reports the maximum length
    assert_trunc_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && trunc_err_o |-> frame_len_o == LEN_W'(MAX_FRAME));

    // R7: full rises only with a completed frame above the limit
    assert_full_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_full_o) |-> done_o && (frame_len_o > LEN_W'(FULL_LIM)));
endmodule

// File: tb/txf_assembler_tb.sv
module txf_assembler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_a = 1'b0, start_b = 1'b0;
    logic [47:0] dst = '0, src = '0;
    logic [15:0] typ = '0;
    logic [7:0]  pl_data;
    logic        pl_valid, pl_last, pl_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        done, trunc_err, q_clr = 1'b0, q_full;
    logic [10:0] frame_len;

    int checks = 0, errors = 0;
    int pl_cnt = 0, pl_start = 0, pl_len = 0;
    logic pl_active = 1'b0;
    logic [7:0] pl_mem [0:1599];
    logic [7:0] exp_mem [0:1599];
    logic [7:0] got_mem [0:2047];
    int got_n = 0, base = 0, cur_plen = 0;
    int done_cnt = 0, cap_len = 0;
    logic cap_err = 1'b0;
    int hold_bad = 0, rdy_bad = 0;
    int stall_mode = 0;
    logic inject = 1'b0, injected = 1'b0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    txf_assembler u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_a | start_b),
        .dst_addr_i(dst), .src_addr_i(src), .type_i(typ),
        .pl_data_i(pl_data), .pl_valid_i(pl_valid), .pl_last_i(pl_last),
        .pl_ready_o(pl_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
        .tx_ready_i(tx_ready), .done_o(done), .frame_len_o(frame_len),
        .trunc_err_o(trunc_err), .q_clr_i(q_clr), .q_full_o(q_full)
    );

    assign pl_valid = pl_active && ((pl_cnt - pl_start) < pl_len);
    assign pl_data  = pl_mem[(pl_cnt - pl_start) % 1600];
    assign pl_last  = pl_valid && ((pl_cnt - pl_start) == pl_len - 1);

    always @(posedge clk) begin
        if (pl_valid && pl_ready) pl_cnt <= pl_cnt + 1;
        if (tx_valid && tx_ready) begin
            got_mem[got_n % 2048] <= tx_data;
            got_n <= got_n + 1;
        end
    end

    always @(negedge clk) begin
        if (prev_stall && !(tx_valid && tx_data == prev_data)) hold_bad++;
        if (pl_active && pl_ready &&
            ((got_n - base) < 14 || (cur_plen < 46 && (got_n - base) >= 14 + cur_plen)))
            rdy_bad++;
        if (done) begin
            done_cnt++;
            cap_len = int'(frame_len);
            cap_err = trunc_err;
        end
        start_b = 1'b0;
        if (inject && !injected && (got_n - base) == 20) begin
            start_b  = 1'b1;
            injected = 1'b1;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = (stall_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
    end

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int plen, input int mode, input logic inj,
                             input logic [47:0] d, input logic [47:0] s,
                             input logic [15:0] t, input string tag);
        int kept, elen, nd, bad, got;
        kept = (plen > 1500) ? 1500 : plen;
        elen = (14 + kept < 60) ? 60 : 14 + kept;
        for (int i = 0; i < 6; i++) exp_mem[i] = d[47-8*i -: 8];
        for (int i = 0; i < 6; i++) exp_mem[6+i] = s[47-8*i -: 8];
        exp_mem[12] = t[15:8];
        exp_mem[13] = t[7:0];
        for (int i = 0; i < 1600; i++) pl_mem[i] = 8'((i * 7 + plen) & 8'hFF);
        for (int i = 0; i < kept; i++) exp_mem[14+i] = pl_mem[i];
        for (int i = 14 + kept; i < elen; i++) exp_mem[i] = 8'h00;
        @(negedge clk);
        stall_mode = mode;
        inject = inj;
        injected = 1'b0;
        base = got_n;
        cur_plen = plen;
        nd = done_cnt;
        dst = d; src = s; typ = t;
        pl_start = pl_cnt;
        pl_len = plen;
        pl_active = 1'b1;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        dst = ~d; src = ~s; typ = ~t;
        while (done_cnt == nd) @(negedge clk);
        repeat (3) @(negedge clk);
        pl_active = 1'b0;
        inject = 1'b0;
        stall_mode = 0;
        got = got_n - base;
        bad = 0;
        for (int i = 0; i < elen && i < got; i++)
            if (got_mem[(base + i) % 2048] !== exp_mem[i]) bad++;
        chk(got == elen, {tag, " R2 R3 byte count"}, got, elen);
        chk(bad == 0, {tag, " R1 R2 R3 byte content mismatches"}, bad, 0);
        chk(done_cnt == nd + 1, {tag, " R4 done pulses"}, done_cnt - nd, 1);
        chk(cap_len == elen, {tag, " R4 frame_len"}, cap_len, elen);
        chk(int'(frame_len) == elen, {tag, " R4 frame_len held"}, int'(frame_len), elen);
        chk(cap_err == (plen > 1500), {tag, " R9 trunc flag"}, int'(cap_err), int'(plen > 1500));
        chk(pl_cnt - pl_start == plen, {tag, " R9 payload consumed"}, pl_cnt - pl_start, plen);
    endtask

    task automatic t_reset;
        chk(!tx_valid && !pl_ready && !done, "R11 idle outputs", int'(tx_valid | pl_ready | done), 0);
        chk(!q_full && !trunc_err, "R11 flags", int'(q_full | trunc_err), 0);
        chk(frame_len == 0, "R11 length", int'(frame_len), 0);
    endtask

    task automatic t_short;
        run_frame(10, 0, 1'b0, 48'h0123_4567_89AB, 48'hFEDC_BA98_7654, 16'h0800, "short");
        chk(rdy_bad == 0, "R6 ready outside payload", rdy_bad, 0);
    endtask

    task automatic t_exact;
        run_frame(46, 0, 1'b0, 48'hFFFF_FFFF_FFFF, 48'h0200_0000_0001, 16'h0806, "exact46");
        run_frame(1, 0, 1'b0, 48'h1111_2222_3333, 48'h4444_5555_6666, 16'h86DD, "one");
    endtask

    task automatic t_stall;
        run_frame(100, 1, 1'b0, 48'hA5A5_5A5A_C3C3, 48'h0F0F_F0F0_1234, 16'h9000, "stall");
        run_frame(20, 1, 1'b0, 48'h0000_0000_0001, 48'h8000_0000_0000, 16'h00FF, "stallpad");
        chk(hold_bad == 0, "R5 hold under stall", hold_bad, 0);
        chk(rdy_bad == 0, "R6 ready during pad with stall", rdy_bad, 0);
    endtask

    task automatic t_busy;
        run_frame(30, 1, 1'b1, 48'hDEAD_BEEF_0001, 48'hCAFE_F00D_0002, 16'h1234, "R10 busy start");
        chk(injected == 1'b1, "R10 start injected mid-frame", int'(injected), 1);
        repeat (4) @(negedge clk);
        chk(!tx_valid, "R10 no frame from ignored start", int'(tx_valid), 0);
    endtask

    task automatic t_full;
        run_frame(504, 0, 1'b0, 48'h1, 48'h2, 16'h0800, "len518");
        chk(!q_full, "R7 no full at 518", int'(q_full), 0);
        run_frame(505, 1, 1'b0, 48'h3, 48'h4, 16'h0800, "len519");
        chk(q_full, "R7 full at 519", int'(q_full), 1);
        run_frame(5, 0, 1'b0, 48'h5, 48'h6, 16'h0800, "afterfull");
        chk(q_full, "R7 full sticky", int'(q_full), 1);
        @(negedge clk); q_clr = 1'b1;
        @(negedge clk); q_clr = 1'b0;
        chk(!q_full, "R8 clear", int'(q_full), 0);
    endtask

    task automatic t_limit;
        run_frame(1500, 0, 1'b0, 48'h7, 48'h8, 16'h88B5, "max1500");
        chk(q_full, "R7 full at 1514", int'(q_full), 1);
        chk(!trunc_err, "R9 no error at exactly 1500", int'(trunc_err), 0);
        run_frame(1503, 1, 1'b0, 48'h9, 48'hA, 16'h88B6, "R9 trunc");
        chk(trunc_err, "R9 error held", int'(trunc_err), 1);
        run_frame(12, 0, 1'b0, 48'hB, 48'hC, 16'h0800, "R9 clear");
        chk(!trunc_err, "R9 error cleared by new frame", int'(trunc_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_short();
        t_exact();
        t_stall();
        t_busy();
        t_full();
        t_limit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule